// File: doc/BRIEF.md
# Quad-Channel Serial DAC Command Interface

This block is the digital front end of a four-channel digital-to-analog converter. A host sends 16-bit words over a three-wire port: an active-low select, a data line and a shift clock. The top four bits of each word are an operation code. The remaining bits carry a sample, aligned to the top of the field. Each channel has two registers. The staging buffer receives new samples. The output register drives the converter.

The operation code picks one channel, or all four channels, and one of three actions. The action either writes the staging buffer, copies the staging buffer into the output register, or does both at once. One spare code does nothing. A word counts only if exactly sixteen shift-clock rises happen while the select is low. The operation runs when the select goes high again. An active-low asynchronous clear empties every register and aborts any word in progress.

The serial pins are oversampled by the system clock, which must run at least four times faster than the shift clock. A receive state machine has four states:
- `ST_IDLE`: select high.
- `ST_SHIFT`: fewer than 16 bits taken.
- `ST_FULL`: exactly 16 bits taken.
- `ST_OVER`: more than 16 bits taken.

It has these transitions:
- Select falling: `ST_IDLE` to `ST_SHIFT`.
- Sixteenth rise: `ST_SHIFT` to `ST_FULL`.
- Extra rise: `ST_FULL` to `ST_OVER`.
- Select rising: any state back to `ST_IDLE`. This transition executes the word only when it leaves `ST_FULL`.

Top module: `quad_dac_front`

## Requirements
- R1: After the clear input is released, all four output words read zero.
- R2: Bits enter most significant first, one per rising shift clock. Codes 0010, 0101, 1000 and 1011 write the sample into the buffer and the output of channel A, B, C and D respectively.
- R3: Codes 0000, 0011, 0110 and 1001 write only the staging buffer of channel A, B, C or D. The output word of that channel does not change.
- R4: Codes 0001, 0100, 0111 and 1010 copy the staging buffer of channel A, B, C or D to its output. The sample field of such a word has no effect.
- R5: Codes 1100, 1110 and 1101 apply the write-buffer, write-both and copy actions to all four channels in the same cycle.
- R6: Code 1111 leaves every output and every buffer unchanged.
- R7: A word with fewer or more than 16 clock rises while select is low is discarded, and no register changes.
- R8: With resolution RES (8, 10 or 12), the sample is taken from word bits 11 down to 12-RES. The lower bits are ignored.
- R9: Output words change only in the cycle after a complete word executes.
- R10: A clear during a word aborts that word. Bits that arrive later in the same select-low period are counted from zero, and the staging buffers read zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| clr_n | input | 1 | Active-low asynchronous clear |
| cs_n | input | 1 | Active-low word select |
| sck | input | 1 | Shift clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| out_a | output | RES | Output register of channel A |
| out_b | output | RES | Output register of channel B |
| out_c | output | RES | Output register of channel C |
| out_d | output | RES | Output register of channel D |

## Verification
The hardest case to reach is a clear in the middle of a word followed by more bits in the same select-low period. The receiver must restart its count there, and the bits left over must not form a valid word. The stimulus holds select low, shifts eight bits, pulses the clear, then shifts eight more bits before raising select. It then issues a broadcast copy to show that the staging buffers were emptied. Short and long words of 15 and 17 bits surround valid frames. Two instances at 12-bit and 8-bit resolution share the same pins, which shows where the sample field is taken.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int NCH     = 4;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } rx_state_e;
endpackage

// File: rtl/dac_sif_rx.sv
module dac_sif_rx
    import qdac_pkg::*;
#(
    parameter int FRAME_W_P = FRAME_W
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 sdi,
    output logic [FRAME_W_P-1:0] frame,
    output logic                 exec
);
    localparam int CNT_W = $clog2(FRAME_W_P);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W_P - 1);

    rx_state_e state, nxt;
    logic s_cs, s_sck, s_sdi, sck_d;
    logic sck_rise;
    logic [CNT_W-1:0] cnt;

    // pin sampling into the system clock domain
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            s_cs  <= 1'b1;
            s_sck <= 1'b0;
            s_sdi <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            s_cs  <= cs_n;
            s_sck <= sck;
            s_sdi <= sdi;
            sck_d <= s_sck;
        end
    end

    assign sck_rise = s_sck & ~sck_d;

    // state register
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!s_cs) nxt = ST_SHIFT;
            ST_SHIFT: if (s_cs) nxt = ST_IDLE;
                      else if (sck_rise && cnt == LAST) nxt = ST_FULL;
            ST_FULL:  if (s_cs) nxt = ST_IDLE;
                      else if (sck_rise) nxt = ST_OVER;
            ST_OVER:  if (s_cs) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // shift path and bit counter
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt   <= '0;
            frame <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= '0;
        end else if (state == ST_SHIFT && !s_cs && sck_rise) begin
            frame <= {frame[FRAME_W_P-2:0], s_sdi};
            cnt   <= cnt + 1'b1;
        end
    end

    // output process: execute strobe on leaving a full frame
    always_comb begin
        exec = 1'b0;
        unique case (state)
            ST_FULL:  exec = s_cs;
            default:  exec = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import qdac_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output logic [NCH-1:0]   ld,
    output logic [NCH-1:0]   up
);
    logic [CMD_W-1:0] grp;
    logic [CMD_W-1:0] op;

    always_comb begin
        ld  = '0;
        up  = '0;
        grp = code / CMD_W'(3);
        op  = code - grp * CMD_W'(3);
        if (code < CMD_W'(12)) begin
            ld[grp[1:0]] = (op != CMD_W'(1));
            up[grp[1:0]] = (op != CMD_W'(0));
        end else if (code != '1) begin
            ld = {NCH{op != CMD_W'(1)}};
            up = {NCH{op != CMD_W'(0)}};
        end
    end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
    import qdac_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           clr_n,
    input  logic           exec,
    input  logic [NCH-1:0] ld,
    input  logic [NCH-1:0] up,
    input  logic [RES-1:0] din,
    output logic [RES-1:0] buf_q [NCH],
    output logic [RES-1:0] out_q [NCH]
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                buf_q[ch] <= '0;
                out_q[ch] <= '0;
            end else if (exec) begin
                if (ld[ch]) buf_q[ch] <= din;
                if (up[ch]) out_q[ch] <= ld[ch] ? din : buf_q[ch];
            end
        end
    end
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
    import qdac_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           clr_n,
    input  logic           cs_n,
    input  logic           sck,
    input  logic           sdi,
    output logic [RES-1:0] out_a,
    output logic [RES-1:0] out_b,
    output logic [RES-1:0] out_c,
    output logic [RES-1:0] out_d
);
    localparam int FIELD_MSB = FRAME_W - CMD_W - 1;

    logic [FRAME_W-1:0] frame_w;
    logic               exec_w;
    logic [CMD_W-1:0]   cmd_w;
    logic [RES-1:0]     din_w;
    logic [NCH-1:0]     ld_w, up_w;
    logic [RES-1:0]     buf_q [NCH];
    logic [RES-1:0]     out_q [NCH];

    dac_sif_rx #(.FRAME_W_P(FRAME_W)) rx_i (
        .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .frame(frame_w), .exec(exec_w)
    );

    assign cmd_w = frame_w[FRAME_W-1 -: CMD_W];
    assign din_w = frame_w[FIELD_MSB -: RES];

    dac_cmd_decode dec_i (.code(cmd_w), .ld(ld_w), .up(up_w));

    dac_chan_regs #(.RES(RES)) regs_i (
        .clk(clk), .clr_n(clr_n), .exec(exec_w), .ld(ld_w), .up(up_w),
        .din(din_w), .buf_q(buf_q), .out_q(out_q)
    );

    assign out_a = out_q[0];
    assign out_b = out_q[1];
    assign out_c = out_q[2];
    assign out_d = out_q[3];
endmodule

// File: rtl/quad_dac_front_chk.sv
module quad_dac_front_chk #(
    parameter int RES = 12
) (
    input logic           clk,
    input logic           clr_n,
    input logic           exec,
    input logic [3:0]     code,
    input logic [RES-1:0] din,
    input logic [RES-1:0] buf_a,
    input logic [RES-1:0] out_a,
    input logic [RES-1:0] out_b,
    input logic [RES-1:0] out_c,
    input logic [RES-1:0] out_d
);
    // R9
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !exec |=> $stable({out_a, out_b, out_c, out_d}));

    // R6
    nop_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (exec && code == 4'hF) |=> $stable({out_a, out_b, out_c, out_d}));

    // R3
    load_only_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (exec && code == 4'h0) |=> $stable(out_a));

    // R4
    update_from_buf_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (exec && code == 4'h1) |=> out_a == $past(buf_a));

    // R2
    load_update_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (exec && code == 4'h2) |=> out_a == $past(din));

    // R5
    bcast_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (exec && code == 4'hE) |=> (out_a == $past(din) && out_d == $past(din)));
endmodule

bind quad_dac_front quad_dac_front_chk #(.RES(RES)) chk_i (
    .clk(clk), .clr_n(clr_n), .exec(exec_w), .code(cmd_w), .din(din_w),
    .buf_a(buf_q[0]), .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
);

// File: tb/quad_dac_front_tb_top.sv
module quad_dac_front_tb_top;
    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic [11:0] a12, b12, c12, d12;
    logic [7:0]  a8, b8, c8, d8;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [47:0] exp;
    } item_t;
    item_t sbq[$];

    logic [11:0] mbuf [4];
    logic [11:0] mout [4];

    always #2 clk = ~clk;

    quad_dac_front #(.RES(12)) dut_i (
        .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .out_a(a12), .out_b(b12), .out_c(c12), .out_d(d12)
    );

    quad_dac_front #(.RES(8)) dut8_i (
        .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .out_a(a8), .out_b(b8), .out_c(c8), .out_d(d8)
    );

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            mbuf[i] = '0;
            mout[i] = '0;
        end
    endtask

    // reference behaviour written from the requirement list
    task automatic model_apply(logic [15:0] w);
        logic [3:0]  c;
        logic [11:0] d;
        c = w[15:12];
        d = w[11:0];
        for (int ch = 0; ch < 4; ch++) begin
            bit hit;
            int op;
            hit = 0;
            op = 0;
            if (c < 12 && int'(c) / 3 == ch) begin hit = 1; op = int'(c) % 3; end
            if (c >= 12 && c != 15) begin hit = 1; op = int'(c) - 12; end
            if (hit) begin
                if (op == 1) mout[ch] = mbuf[ch];
                else begin
                    mbuf[ch] = d;
                    if (op == 2) mout[ch] = d;
                end
            end
        end
    endtask

    task automatic push(string tag);
        item_t it;
        @(posedge clk);
        it.tag = tag;
        it.exp = {mout[0], mout[1], mout[2], mout[3]};
        sbq.push_back(it);
    endtask

    task automatic drive_bit(logic b);
        sck = 1'b0;
        sdi = b;
        wait_n(4);
        sck = 1'b1;
        wait_n(4);
        sck = 1'b0;
    endtask

    task automatic send(int nbits, logic [15:0] w, string tag);
        cs_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nbits; i++) drive_bit(i < 16 ? w[15 - i] : 1'b0);
        wait_n(4);
        cs_n = 1'b1;
        wait_n(6);
        if (nbits == 16) model_apply(w);
        push(tag);
    endtask

    function automatic logic [31:0] narrow(logic [47:0] e);
        return {e[47:40], e[35:28], e[23:16], e[11:4]};
    endfunction

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                logic [47:0] act12;
                logic [31:0] act8;
                it = sbq.pop_front();
                act12 = {a12, b12, c12, d12};
                act8 = {a8, b8, c8, d8};
                checks++;
                if (act12 !== it.exp || act8 !== narrow(it.exp)) begin
                    fails++;
                    $display("FAIL %s: act12=%h exp12=%h act8=%h exp8=%h",
                             it.tag, act12, it.exp, act8, narrow(it.exp));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        wait_n(5);
        clr_n = 1'b1;
        wait_n(3);
        push("R1 reset state");

        send(16, 16'h2ABC, "R2 load+update A");
        send(16, 16'h5123, "R2 load+update B");
        send(16, 16'h89F0, "R2 load+update C");
        send(16, 16'hB00F, "R2 load+update D");

        send(16, 16'h0555, "R3 load only A");
        send(16, 16'h1FFF, "R4 update A ignores field");

        send(16, 16'h3777, "R3 load only B");
        send(16, 16'h6888, "R3 load only C");
        send(16, 16'h9999, "R3 load only D");
        send(16, 16'hD000, "R5 broadcast update");
        send(16, 16'hC246, "R5 broadcast load");
        send(16, 16'hE3C5, "R5 broadcast load+update");

        send(16, 16'hFFFF, "R6 no-op");
        send(15, 16'h2111, "R7 short word");
        send(17, 16'h2111, "R7 long word");
        send(16, 16'h23C7, "R8 field position");
        send(16, 16'hA0F1, "R9 update D from buffer");

        // R10: clear in the middle of a word, then more bits in the same select
        cs_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < 8; i++) drive_bit(i[0]);
        clr_n = 1'b0;
        wait_n(3);
        clr_n = 1'b1;
        model_clear();
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
        wait_n(4);
        cs_n = 1'b1;
        wait_n(6);
        push("R10 clear aborts word");
        send(16, 16'hD5A5, "R10 buffers cleared");

        wait_n(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule